// File: doc/BRIEF.md
# Pseudo-Random Link Test Frame Generator

This block drives the transmit side of a chip-to-chip serial link test. It never waits on the far end. After reset it emits one byte on every clock, forever, arranged in back-to-back frames. Each frame holds four parts in this order:

- a run of clock-correction control bytes;
- a single alignment comma;
- a payload of pseudo-random bytes;
- a four-byte CRC computed over that payload.

A control flag travels beside every byte so that a downstream 8b10b encoder can tell control characters from data. A second flag marks frames that should bypass line coding, which supports error-rate studies against transition density.

Two request inputs let a test controller shape the stream. One corrupts the CRC of a single frame, so the receiver's error detection can be shown to work. The other selects raw transmission for whole frames. A one-cycle strobe marks the first byte of each frame so frames can be counted. Serialization, the line encoder and any clock-domain crossing live outside this block.

Top module: `lfg_frame_gen`

## Requirements
- R1: While `rst` is high, `tx_byte`, `tx_is_k`, `tx_raw` and `frame_start` are all 0. The first byte of the first frame appears on the first rising clock edge that sees `rst` low.
- R2: Each frame is exactly 2*CC_PAIRS+1+PAYLOAD_LEN+4 bytes, and frames follow each other with no gap.
  - The frame opens with 2*CC_PAIRS clock-correction bytes that alternate 0xBC, 0x1C, 0xBC, 0x1C and so on, starting with 0xBC.
  - One comma byte 0xBC follows.
- R3: `tx_is_k` is 1 on the clock-correction bytes and the comma, and 0 on every payload and CRC byte.
- R4: Payload bytes come from a 7-bit PRBS7 register s (x^7+x^6+1).
  - After reset, s holds SEED, which defaults to 0x7F.
  - Each bit step computes n = s[6]^s[5], then sets s = {s[5:0], n}.
  - A payload byte is made of 8 successive n values, with the first one in bit 7.
  - The register advances only on payload bytes and carries over from one frame into the next.
- R5: The four bytes after the payload carry the CRC-32 of the payload bytes, least-significant byte first.
  - Processing is reflected, with polynomial 0xEDB88320.
  - The initial value is 0xFFFFFFFF, and the result is inverted at the end.
- R6: If `crc_bad_req` is high at a rising edge, one frame is marked for corruption.
  - The marked frame is the one whose first byte that edge loads, or otherwise the next frame to start.
  - In a marked frame all four CRC bytes are the bitwise complement of the correct ones.
  - Any number of requests before one frame start mark only that one frame.
- R7: `tx_raw` equals the value of `raw_req` at the edge that loads a frame's first byte. It holds that value for the entire frame, whatever `raw_req` does in between.
- R8: `frame_start` is 1 for exactly the one cycle in which the first clock-correction byte of a frame is on `tx_byte`, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| crc_bad_req | input | 1 | Request to corrupt the CRC of one frame |
| raw_req | input | 1 | Request that frames bypass line coding, sampled at frame start |
| tx_byte | output | 8 | Byte to transmit |
| tx_is_k | output | 1 | Byte is a control character |
| tx_raw | output | 1 | Current frame bypasses line coding |
| frame_start | output | 1 | First byte of a frame |

## Verification
The bench uses a short payload so that the PRBS register wraps its 127-byte period across frame boundaries. A generator that reseeded per frame, or that stepped during control or CRC bytes, would diverge after the first frame.

Corruption requests are aimed at three points: the middle of a frame, a burst of several requests, and the exact edge that loads a frame's first byte. A design that applied the request one frame late, corrupted two frames for a burst, or forgot to clear the pending mark would show the wrong CRC bytes. A design that seeded the CRC at the wrong time would miscompute every frame.

The raw request is toggled in the middle of frames, to catch a flag that follows the input instead of holding it for the frame. A reset during traffic checks that the stream restarts from the seed.

// File: rtl/lfg_pkg.sv
package lfg_pkg;

    localparam logic [7:0]  SYM_COMMA = 8'hBC;
    localparam logic [7:0]  SYM_SKIP  = 8'h1C;
    localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT  = 32'hFFFFFFFF;

    typedef enum logic [1:0] {
        PH_ALIGN,
        PH_COMMA,
        PH_DATA,
        PH_CHECK
    } phase_e;

    typedef struct packed {
        logic [7:0] data;
        logic       is_k;
        logic       raw;
        logic       start;
    } tx_word_t;

    function automatic logic [7:0] prbs7_byte(input logic [6:0] s);
        logic [6:0] t;
        logic [7:0] r;
        logic       n;
        t = s;
        r = '0;
        for (int i = 7; i >= 0; i--) begin
            n    = t[6] ^ t[5];
            r[i] = n;
            t    = {t[5:0], n};
        end
        return r;
    endfunction

    function automatic logic [6:0] prbs7_next(input logic [6:0] s);
        logic [6:0] t;
        t = s;
        for (int i = 0; i < 8; i++) begin
            t = {t[5:0], t[6] ^ t[5]};
        end
        return t;
    endfunction

    function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/lfg_seq.sv
module lfg_seq
    import lfg_pkg::*;
#(
    parameter int CC_PAIRS    = 2,
    parameter int PAYLOAD_LEN = 1024,
    parameter int CW          = 11
) (
    input  logic          clk,
    input  logic          rst,
    output phase_e        phase,
    output logic [CW-1:0] idx
);
    localparam logic [CW-1:0] LAST_ALIGN = CW'(2 * CC_PAIRS - 1);
    localparam logic [CW-1:0] LAST_DATA  = CW'(PAYLOAD_LEN - 1);
    localparam logic [CW-1:0] LAST_CHECK = CW'(3);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_ALIGN;
            idx   <= '0;
        end else begin
            unique case (phase)
                PH_ALIGN: begin
                    if (idx == LAST_ALIGN) begin
                        phase <= PH_COMMA;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_COMMA: begin
                    phase <= PH_DATA;
                    idx   <= '0;
                end
                PH_DATA: begin
                    if (idx == LAST_DATA) begin
                        phase <= PH_CHECK;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: begin
                    if (idx == LAST_CHECK) begin
                        phase <= PH_ALIGN;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/lfg_prbs.sv
module lfg_prbs
    import lfg_pkg::*;
#(
    parameter logic [6:0] SEED = 7'h7F
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       adv,
    output logic [7:0] byte_o,
    output logic [6:0] state_o
);
    logic [6:0] st_q;

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= SEED;
        else if (adv)
            st_q <= prbs7_next(st_q);
    end

    assign byte_o  = prbs7_byte(st_q);
    assign state_o = st_q;
endmodule

// File: rtl/lfg_crc.sv
module lfg_crc
    import lfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [31:0] crc_o
);
    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            crc_q <= CRC_INIT;
        else if (en)
            crc_q <= crc32_byte(crc_q, data);
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/lfg_frame_gen.sv
module lfg_frame_gen
    import lfg_pkg::*;
#(
    parameter int         CC_PAIRS    = 2,
    parameter int         PAYLOAD_LEN = 1024,
    parameter logic [6:0] SEED        = 7'h7F
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       crc_bad_req,
    input  logic       raw_req,
    output logic [7:0] tx_byte,
    output logic       tx_is_k,
    output logic       tx_raw,
    output logic       frame_start
);
    localparam int FRAME_LEN = 2 * CC_PAIRS + 1 + PAYLOAD_LEN + 4;
    localparam int CW        = $clog2(FRAME_LEN);

    phase_e        phase;
    logic [CW-1:0] idx;
    logic [7:0]    prbs_byte;
    logic [6:0]    prbs_state;
    logic [31:0]   crc_run;
    logic          first;
    logic          bad_pend_q;
    logic          bad_frame_q;
    logic          raw_frame_q;
    logic [31:0]   crc_send;
    tx_word_t      word_d;
    tx_word_t      word_q;

    lfg_seq #(.CC_PAIRS(CC_PAIRS), .PAYLOAD_LEN(PAYLOAD_LEN), .CW(CW)) u_seq (
        .clk(clk), .rst(rst), .phase(phase), .idx(idx)
    );

    lfg_prbs #(.SEED(SEED)) u_prbs (
        .clk(clk), .rst(rst), .adv(phase == PH_DATA),
        .byte_o(prbs_byte), .state_o(prbs_state)
    );

    lfg_crc u_crc (
        .clk(clk), .rst(rst), .clear(first), .en(phase == PH_DATA),
        .data(prbs_byte), .crc_o(crc_run)
    );

    assign first    = (phase == PH_ALIGN) && (idx == '0);
    assign crc_send = bad_frame_q ? crc_run : ~crc_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_pend_q  <= 1'b0;
            bad_frame_q <= 1'b0;
            raw_frame_q <= 1'b0;
        end else if (first) begin
            bad_frame_q <= bad_pend_q | crc_bad_req;
            bad_pend_q  <= 1'b0;
            raw_frame_q <= raw_req;
        end else begin
            bad_pend_q <= bad_pend_q | crc_bad_req;
        end
    end

    always_comb begin
        word_d.start = first;
        word_d.raw   = first ? raw_req : raw_frame_q;
        word_d.is_k  = 1'b0;
        word_d.data  = '0;
        unique case (phase)
            PH_ALIGN: begin
                word_d.is_k = 1'b1;
                word_d.data = idx[0] ? SYM_SKIP : SYM_COMMA;
            end
            PH_COMMA: begin
                word_d.is_k = 1'b1;
                word_d.data = SYM_COMMA;
            end
            PH_DATA: begin
                word_d.data = prbs_byte;
            end
            default: begin
                word_d.data = crc_send[8*idx[1:0] +: 8];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= '0;
        else
            word_q <= word_d;
    end

    assign tx_byte     = word_q.data;
    assign tx_is_k     = word_q.is_k;
    assign tx_raw      = word_q.raw;
    assign frame_start = word_q.start;
endmodule

// File: rtl/lfg_checker.sv
module lfg_checker
    import lfg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [7:0] tx_byte,
    input logic       tx_is_k,
    input logic       tx_raw,
    input logic       frame_start,
    input logic [6:0] lfsr_state
);
    a_r8_start_on_comma: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (tx_is_k && tx_byte == SYM_COMMA));

    a_r8_start_single: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    a_r2_second_is_skip: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (tx_is_k && tx_byte == SYM_SKIP));

    a_r3_k_codes_only: assert property (@(posedge clk) disable iff (rst)
        tx_is_k |-> (tx_byte == SYM_COMMA || tx_byte == SYM_SKIP));

    a_r7_raw_held: assert property (@(posedge clk) disable iff (rst)
        !frame_start |-> $stable(tx_raw));

    a_r4_lfsr_live: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != 7'h00);
endmodule

bind lfg_frame_gen lfg_checker u_lfg_checker (
    .clk(clk), .rst(rst), .tx_byte(tx_byte), .tx_is_k(tx_is_k),
    .tx_raw(tx_raw), .frame_start(frame_start), .lfsr_state(prbs_state)
);

// File: tb/test_lfg_frame_gen.sv
module test_lfg_frame_gen;
    localparam int CCP = 2;
    localparam int LEN = 16;
    localparam int FL  = 2 * CCP + 1 + LEN + 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       crc_bad_req = 1'b0;
    logic       raw_req = 1'b0;
    logic [7:0] tx_byte;
    logic       tx_is_k;
    logic       tx_raw;
    logic       frame_start;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench reference state
    int          m_pos;
    logic [6:0]  m_lfsr;
    logic [31:0] m_crc;
    logic        m_pend;
    logic        m_bad;
    logic        m_raw;
    logic [7:0]  e_byte;
    logic        e_k, e_start, e_raw;
    string       e_tag;

    always #5 clk = ~clk;

    lfg_frame_gen #(.CC_PAIRS(CCP), .PAYLOAD_LEN(LEN), .SEED(7'h7F)) i_lfg_frame_gen (
        .clk(clk), .rst(rst), .crc_bad_req(crc_bad_req), .raw_req(raw_req),
        .tx_byte(tx_byte), .tx_is_k(tx_is_k), .tx_raw(tx_raw), .frame_start(frame_start)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pos  = 0;
        m_lfsr = 7'h7F;
        m_crc  = 32'hFFFFFFFF;
        m_pend = 1'b0;
        m_bad  = 1'b0;
        m_raw  = 1'b0;
    endtask

    // Predict the byte loaded at the coming edge from the inputs driven now.
    task automatic model_step();
        logic       nb;
        logic [7:0] b;
        logic [31:0] v;
        int j;
        if (m_pos == 0) begin
            m_bad  = m_pend | crc_bad_req;
            m_pend = 1'b0;
            m_raw  = raw_req;
            m_crc  = 32'hFFFFFFFF;
        end else begin
            m_pend = m_pend | crc_bad_req;
        end
        e_start = (m_pos == 0);
        e_raw   = m_raw;
        if (m_pos < 2 * CCP) begin
            e_byte = (m_pos % 2 == 1) ? 8'h1C : 8'hBC;
            e_k = 1'b1; e_tag = "R2";
        end else if (m_pos == 2 * CCP) begin
            e_byte = 8'hBC; e_k = 1'b1; e_tag = "R2";
        end else if (m_pos < 2 * CCP + 1 + LEN) begin
            b = '0;
            for (int i = 7; i >= 0; i--) begin
                nb = m_lfsr[6] ^ m_lfsr[5];
                b[i] = nb;
                m_lfsr = {m_lfsr[5:0], nb};
            end
            for (int i = 0; i < 8; i++) begin
                if ((m_crc[0] ^ b[i]) == 1'b1) m_crc = (m_crc >> 1) ^ 32'hEDB88320;
                else                          m_crc = m_crc >> 1;
            end
            e_byte = b; e_k = 1'b0; e_tag = "R4";
        end else begin
            j = m_pos - (2 * CCP + 1 + LEN);
            v = m_bad ? m_crc : ~m_crc;
            e_byte = v[8*j +: 8]; e_k = 1'b0;
            e_tag = m_bad ? "R6" : "R5";
        end
        m_pos = (m_pos + 1) % FL;
    endtask

    task automatic tick_check();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(tx_byte == e_byte, e_tag, 32'(tx_byte), 32'(e_byte));
        chk(tx_is_k == e_k, "R3 k flag", 32'(tx_is_k), 32'(e_k));
        chk(frame_start == e_start, "R8 frame start", 32'(frame_start), 32'(e_start));
        chk(tx_raw == e_raw, "R7 raw flag", 32'(tx_raw), 32'(e_raw));
    endtask

    task automatic reset_check();
        @(posedge clk);
        @(negedge clk);
        chk(tx_byte == 8'h00, "R1 reset byte", 32'(tx_byte), 32'h0);
        chk(tx_is_k == 1'b0, "R1 reset k", 32'(tx_is_k), 32'h0);
        chk(tx_raw == 1'b0, "R1 reset raw", 32'(tx_raw), 32'h0);
        chk(frame_start == 1'b0, "R1 reset start", 32'(frame_start), 32'h0);
    endtask

    initial begin
        #(20_000 * 10);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        raw_req = 1'b1;
        crc_bad_req = 1'b1;
        for (int i = 0; i < 3; i++) reset_check();
        raw_req = 1'b0;
        crc_bad_req = 1'b0;
        rst = 1'b0;
        for (int n = 0; n < 360; n++) begin
            crc_bad_req = (n == 40) || (n >= 120 && n < 125) || (n == 60)
                        || (n >= 200 && n < 260 && m_pos == 0 && n < 230);
            raw_req = (n >= 57 && n < 160) || (n > 250 && (n % 7 == 0));
            tick_check();
        end
        crc_bad_req = 1'b0;
        raw_req = 1'b0;
        // R1: reset during traffic restarts from the seed
        rst = 1'b1;
        reset_check();
        reset_check();
        model_reset();
        rst = 1'b0;
        for (int n = 0; n < 3 * FL; n++) begin
            crc_bad_req = (n == FL + 3);
            raw_req = (n == 2 * FL);
            tick_check();
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule